// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Bank

This block manages a bank of general-purpose pins whose pads are also used by other peripheral functions. Software gives each pin one of three modes: a driven output, a plain input, or an input that raises an interrupt. Each interrupting pin has its own trigger, which can be a rising edge, a falling edge, a low level or a high level. Pad inputs pass through a two-flop synchronizer before any edge or level detection.

A small word-addressed register file holds the per-pin configuration. It also shows the synchronized pad levels and the interrupt status bits, which are cleared by writing one. Writes take effect on the clock edge that samples `reg_we`. Reads are combinational from `reg_addr`. One combined interrupt line is high while any status bit is set and its enable is also set. A per-pin select input hands a pad to its peripheral. For a pin handed over this way, the output driver follows the peripheral, and interrupt detection for that pin is switched off.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous reset, every register reads zero, `pad_oe` and `pad_out` are all zero, and `irq` is low.
- R2: Mode is 2 bits per pin, encoded 00 plain input, 01 output, 10 interrupt input, 11 treated as plain input. A pin in mode 01 with its peripheral select low drives `pad_oe`=1 and `pad_out` equal to its output-value bit. Every other non-peripheral pin drives `pad_oe`=0 and `pad_out`=0.
- R3: When `periph_sel[i]` is high, `pad_oe[i]` and `pad_out[i]` follow `periph_oe[i]` and `periph_out[i]`, and pin i never sets its status bit.
- R4: The input-value register shows bit i of `pin_in` after it has crossed two flops. A change driven before clock edge k reads back after edge k+1, and does not read back after edge k alone.
- R5: Trigger code 00 (rising) sets status bit i on the third clock edge after `pin_in[i]` goes 0 to 1. A 1 to 0 transition does not set the bit.
- R6: Trigger code 01 (falling) sets status bit i on the third clock edge after `pin_in[i]` goes 1 to 0. A rising transition does not set the bit.
- R7: Trigger code 10 (low level) sets the status bit every cycle the synchronized pin is low. Clearing it while the pin is still low leaves the bit set. Once the pin is high, clearing it removes the bit.
- R8: Trigger code 11 (high level) behaves like R7 with the level inverted.
- R9: Status bits stay set until a one is written to the matching bit at the status offset. Writing zero bits has no effect. If a new event and a clear arrive on the same edge, the event wins.
- R10: Pins in plain input mode or output mode never set status, whatever their pads do.
- R11: A status bit is set whatever the value of its enable. `irq` is high exactly when some status bit and its enable bit are both one.
- R12: The word offsets are: mode 0, output value 1, input value 2 (read only), trigger 3, enable 4, status 5. Mode and trigger for pin i sit at bits 2i+1:2i. The other registers use bit i. Unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register word offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DW (2*NPINS) | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| pin_in | input | NPINS | Asynchronous pad input levels |
| periph_sel | input | NPINS | Per-pin handover to the peripheral |
| periph_out | input | NPINS | Peripheral output values |
| periph_oe | input | NPINS | Peripheral output enables |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output enable |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a status clear that lands on the same clock edge as a new edge event on the same pin. In that case the event must survive while a different pin's bit in the same write is removed. To reach it, the stimulus changes the pad on a falling clock edge, waits exactly two rising edges, and then issues the clear so that its sampling edge coincides with the third edge, where detection completes. Level triggers get the related case: a clear is written while the level is still present and must not take effect.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

    localparam int REG_AW = 3;
    typedef logic [REG_AW-1:0] reg_addr_t;

    localparam reg_addr_t OFS_MODE = 3'd0;
    localparam reg_addr_t OFS_OUT  = 3'd1;
    localparam reg_addr_t OFS_IN   = 3'd2;
    localparam reg_addr_t OFS_TRIG = 3'd3;
    localparam reg_addr_t OFS_IEN  = 3'd4;
    localparam reg_addr_t OFS_STAT = 3'd5;

    typedef enum logic [1:0] {
        PM_INPUT  = 2'b00,
        PM_DRIVE  = 2'b01,
        PM_LISTEN = 2'b10,
        PM_SPARE  = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        TG_RISE = 2'b00,
        TG_FALL = 2'b01,
        TG_LOW  = 2'b10,
        TG_HIGH = 2'b11
    } trig_e;

    typedef struct packed {
        pin_mode_e mode;
        trig_e     trig;
        logic      out_val;
        logic      irq_en;
    } pin_cfg_t;

    // True when the current and previous synchronized samples match the trigger.
    function automatic logic trig_hit(trig_e t, logic cur, logic prev);
        case (t)
            TG_RISE: return cur & ~prev;
            TG_FALL: return ~cur & prev;
            TG_LOW:  return ~cur;
            default: return cur;
        endcase
    endfunction

    function automatic logic mode_listens(pin_mode_e m);
        return m == PM_LISTEN;
    endfunction

    function automatic logic mode_drives(pin_mode_e m);
        return m == PM_DRIVE;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;
endmodule

// File: rtl/gpio_pin_detect.sv
`timescale 1ns/1ps
module gpio_pin_detect
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lvl,
    input  pin_cfg_t cfg,
    input  logic     handed_over,
    output logic     hit
);
    logic lvl_prev;

    // Previous sample tracks always, so changing trigger or mode creates no false edge.
    always_ff @(posedge clk) begin
        if (rst) lvl_prev <= 1'b0;
        else     lvl_prev <= lvl;
    end

    always_comb begin
        hit = 1'b0;
        if (mode_listens(cfg.mode) && !handed_over)
            hit = trig_hit(cfg.trig, lvl, lvl_prev);
    end
endmodule

// File: rtl/gpio_padmux.sv
`timescale 1ns/1ps
module gpio_padmux
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  pin_cfg_t [NPINS-1:0] cfg,
    input  logic     [NPINS-1:0] periph_sel,
    input  logic     [NPINS-1:0] periph_out,
    input  logic     [NPINS-1:0] periph_oe,
    output logic     [NPINS-1:0] pad_out,
    output logic     [NPINS-1:0] pad_oe
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        always_comb begin
            if (periph_sel[i]) begin
                pad_out[i] = periph_out[i];
                pad_oe[i]  = periph_oe[i];
            end else if (mode_drives(cfg[i].mode)) begin
                pad_out[i] = cfg[i].out_val;
                pad_oe[i]  = 1'b1;
            end else begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = 1'b0;
            end
        end
    end
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int DW    = 2 * NPINS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  reg_addr_t            reg_addr,
    input  logic                 reg_we,
    input  logic     [DW-1:0]    reg_wdata,
    output logic     [DW-1:0]    reg_rdata,
    input  logic     [NPINS-1:0] lvl_sync,
    input  logic     [NPINS-1:0] event_hit,
    output pin_cfg_t [NPINS-1:0] cfg,
    output logic     [NPINS-1:0] stat_q
);
    logic [NPINS-1:0] clr_mask;

    assign clr_mask = (reg_we && reg_addr == OFS_STAT) ? reg_wdata[NPINS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (reg_we) begin
            for (int i = 0; i < NPINS; i++) begin
                case (reg_addr)
                    OFS_MODE: cfg[i].mode    <= pin_mode_e'(reg_wdata[2*i +: 2]);
                    OFS_TRIG: cfg[i].trig    <= trig_e'(reg_wdata[2*i +: 2]);
                    OFS_OUT:  cfg[i].out_val <= reg_wdata[i];
                    OFS_IEN:  cfg[i].irq_en  <= reg_wdata[i];
                    default: ;
                endcase
            end
        end
    end

    // A detection on the same edge as a clear wins, so no event is lost.
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_mask) | event_hit;
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NPINS; i++) begin
            case (reg_addr)
                OFS_MODE: reg_rdata[2*i +: 2] = cfg[i].mode;
                OFS_TRIG: reg_rdata[2*i +: 2] = cfg[i].trig;
                OFS_OUT:  reg_rdata[i]        = cfg[i].out_val;
                OFS_IN:   reg_rdata[i]        = lvl_sync[i];
                OFS_IEN:  reg_rdata[i]        = cfg[i].irq_en;
                OFS_STAT: reg_rdata[i]        = stat_q[i];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int DW    = 2 * NPINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  periph_sel,
    input  logic [NPINS-1:0]  periph_out,
    input  logic [NPINS-1:0]  periph_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq
);
    pin_cfg_t [NPINS-1:0] cfg;
    logic     [NPINS-1:0] lvl_sync;
    logic     [NPINS-1:0] event_hit;
    logic     [NPINS-1:0] stat_q;
    logic     [NPINS-1:0] ien_vec;
    logic     [NPINS-1:0] listen_mask;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_in),
        .q_sync  (lvl_sync)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_det
        gpio_pin_detect u_det (
            .clk         (clk),
            .rst         (rst),
            .lvl         (lvl_sync[i]),
            .cfg         (cfg[i]),
            .handed_over (periph_sel[i]),
            .hit         (event_hit[i])
        );
        assign ien_vec[i]     = cfg[i].irq_en;
        assign listen_mask[i] = mode_listens(cfg[i].mode);
    end

    gpio_regs #(.NPINS(NPINS), .DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lvl_sync  (lvl_sync),
        .event_hit (event_hit),
        .cfg       (cfg),
        .stat_q    (stat_q)
    );

    gpio_padmux #(.NPINS(NPINS)) u_padmux (
        .cfg        (cfg),
        .periph_sel (periph_sel),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    assign irq = |(stat_q & ien_vec);
endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int DW    = 2 * NPINS
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic [NPINS-1:0]  status,
    input logic [NPINS-1:0]  ien,
    input logic [NPINS-1:0]  listen,
    input logic [NPINS-1:0]  periph_sel,
    input logic              irq
);
    // R1: reset empties the status and drops the interrupt
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (status == '0 && !irq));

    // R3: no new status bit on a pin handed to its peripheral
    p_periph_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        ((status & ~$past(status) & $past(periph_sel)) == '0));

    // R9: a set bit survives unless a one was written to it
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (($past(status) & ~status &
          ~(($past(reg_we) && $past(reg_addr) == OFS_STAT) ? $past(reg_wdata[NPINS-1:0]) : '0)) == '0));

    // R10: only pins in interrupt mode can raise new status
    p_mode_gate_r10: assert property (@(posedge clk) disable iff (rst)
        ((status & ~$past(status) & ~$past(listen)) == '0));

    // R11: with no enables the interrupt line stays low
    p_irq_needs_en_r11: assert property (@(posedge clk) disable iff (rst)
        (ien == '0) |-> !irq);
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .DW(DW)) i_gpio_bank_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .status     (stat_q),
    .ien        (ien_vec),
    .listen     (listen_mask),
    .periph_sel (periph_sel),
    .irq        (irq)
);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;
    localparam int N  = 8;
    localparam int DW = 2 * N;
    localparam logic [2:0] A_MODE = 3'd0, A_OUT = 3'd1, A_IN = 3'd2,
                           A_TRIG = 3'd3, A_IEN = 3'd4, A_STAT = 3'd5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    reg_addr = '0;
    logic          reg_we = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  periph_sel = '0;
    logic [N-1:0]  periph_out = '0;
    logic [N-1:0]  periph_oe = '0;
    logic [N-1:0]  pad_out;
    logic [N-1:0]  pad_oe;
    logic          irq;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    gpio_bank #(.NPINS(N), .DW(DW)) i_gpio_bank (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .periph_sel(periph_sel), .periph_out(periph_out), .periph_oe(periph_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [DW-1:0] exp);
        @(negedge clk);
        reg_addr = a; #0.5;
        chk(tag, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic setpin(input int i, input logic v);
        @(negedge clk);
        pin_in[i] = v;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic t_reset;
        rd_chk("R1 mode", A_MODE, '0);
        rd_chk("R1 out", A_OUT, '0);
        rd_chk("R1 in", A_IN, '0);
        rd_chk("R1 trig", A_TRIG, '0);
        rd_chk("R1 ien", A_IEN, '0);
        rd_chk("R1 stat", A_STAT, '0);
        chk("R1 pad_oe", 32'(pad_oe), 0);
        chk("R1 pad_out", 32'(pad_out), 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_regmap;
        wr(A_MODE, 16'hA5C3); rd_chk("R12 mode", A_MODE, 16'hA5C3);
        wr(A_MODE, 16'h0000);
        wr(A_TRIG, 16'h1E2D); rd_chk("R12 trig", A_TRIG, 16'h1E2D);
        wr(A_TRIG, 16'h0000);
        wr(A_IEN, 16'hFF5A);  rd_chk("R12 ien upper bits", A_IEN, 16'h005A);
        wr(A_IEN, 16'h0000);
        wr(A_OUT, 16'h00C3);  rd_chk("R12 out", A_OUT, 16'h00C3);
        wr(A_OUT, 16'h0000);
        wr(A_IN, 16'hFFFF);   rd_chk("R12 in read only", A_IN, 16'h0000);
    endtask

    task automatic t_output;
        wr(A_MODE, 16'h0021);          // pin0 output, pin2 interrupt input
        wr(A_OUT, 16'h0007);
        @(negedge clk);
        chk("R2 pad_oe", 32'(pad_oe), 32'h01);
        chk("R2 pad_out", 32'(pad_out), 32'h01);
        wr(A_OUT, 16'h0000);
        @(negedge clk);
        chk("R2 pad_out low", 32'(pad_out), 32'h00);
        wr(A_MODE, 16'h0000);
    endtask

    task automatic t_periph;
        wr(A_MODE, 16'h0021);
        wr(A_OUT, 16'h0001);
        @(negedge clk);
        periph_sel = 8'h05; periph_out = 8'h04; periph_oe = 8'h05;
        #0.5;
        chk("R3 pad_oe", 32'(pad_oe), 32'h05);
        chk("R3 pad_out", 32'(pad_out), 32'h04);
        setpin(2, 1'b1); edges(4);
        rd_chk("R3 no status while handed over", A_STAT, 16'h0000);
        setpin(2, 1'b0); edges(4);
        @(negedge clk); periph_sel = '0; periph_out = '0; periph_oe = '0;
        setpin(2, 1'b1); edges(3);
        rd_chk("R3 detection back after release", A_STAT, 16'h0004);
        wr(A_STAT, 16'h0004);
        setpin(2, 1'b0); edges(4);
        wr(A_MODE, 16'h0000); wr(A_OUT, 16'h0000);
    endtask

    task automatic t_sync;
        setpin(3, 1'b1); edges(1);
        rd_chk("R4 one flop not visible", A_IN, 16'h0000);
        edges(1);
        rd_chk("R4 visible after two", A_IN, 16'h0008);
        setpin(3, 1'b0); edges(2);
        rd_chk("R4 back low", A_IN, 16'h0000);
    endtask

    task automatic t_rise;
        wr(A_MODE, 16'h0008);          // pin1 interrupt input, trigger 00
        wr(A_IEN, 16'h0002);
        setpin(1, 1'b1); edges(2);
        rd_chk("R5 not yet at edge two", A_STAT, 16'h0000);
        edges(1);
        rd_chk("R5 set at edge three", A_STAT, 16'h0002);
        chk("R5 irq", 32'(irq), 1);
        wr(A_STAT, 16'h0002);
        setpin(1, 1'b0); edges(4);
        rd_chk("R5 falling ignored", A_STAT, 16'h0000);
    endtask

    task automatic t_fall;
        wr(A_TRIG, 16'h0004);          // pin1 trigger 01
        setpin(1, 1'b1); edges(4);
        rd_chk("R6 rising ignored", A_STAT, 16'h0000);
        setpin(1, 1'b0); edges(2);
        rd_chk("R6 not yet", A_STAT, 16'h0000);
        edges(1);
        rd_chk("R6 set on fall", A_STAT, 16'h0002);
        wr(A_STAT, 16'h0002);
    endtask

    task automatic t_level;
        wr(A_TRIG, 16'h0008);          // pin1 trigger 10, pin is low
        edges(1);
        rd_chk("R7 low level sets", A_STAT, 16'h0002);
        wr(A_STAT, 16'h0002);
        rd_chk("R7 reasserts while low", A_STAT, 16'h0002);
        setpin(1, 1'b1); edges(4);
        wr(A_STAT, 16'h0002);
        rd_chk("R7 clears once high", A_STAT, 16'h0000);
        wr(A_TRIG, 16'h000C);          // trigger 11, pin is high
        edges(1);
        rd_chk("R8 high level sets", A_STAT, 16'h0002);
        wr(A_STAT, 16'h0002);
        rd_chk("R8 reasserts while high", A_STAT, 16'h0002);
        setpin(1, 1'b0); edges(4);
        wr(A_STAT, 16'h0002);
        rd_chk("R8 clears once low", A_STAT, 16'h0000);
        wr(A_TRIG, 16'h0000);
    endtask

    task automatic t_sticky;
        wr(A_MODE, 16'h0208);          // pins 1 and 4 interrupt, rising
        setpin(4, 1'b1); edges(3);
        rd_chk("R9 pin4 set", A_STAT, 16'h0010);
        wr(A_STAT, 16'h00ED);
        rd_chk("R9 zero bits no effect", A_STAT, 16'h0010);
        setpin(1, 1'b1); edges(2);
        wr(A_STAT, 16'h0012);          // clear lands on detection edge
        rd_chk("R9 event beats clear", A_STAT, 16'h0002);
        wr(A_STAT, 16'h0002);
        rd_chk("R9 cleared by one", A_STAT, 16'h0000);
        setpin(1, 1'b0); setpin(4, 1'b0); edges(4);
        wr(A_MODE, 16'h0000);
    endtask

    task automatic t_plain;
        wr(A_MODE, 16'h1000);          // pin5 plain input, pin6 output
        wr(A_IEN, 16'h00FF);
        setpin(5, 1'b1); setpin(6, 1'b1); edges(4);
        setpin(5, 1'b0); setpin(6, 1'b0); edges(4);
        rd_chk("R10 no status", A_STAT, 16'h0000);
        chk("R10 no irq", 32'(irq), 0);
        wr(A_MODE, 16'h0000); wr(A_IEN, 16'h0000);
    endtask

    task automatic t_irq;
        wr(A_TRIG, 16'hC000);          // pin7 high level
        wr(A_MODE, 16'h8000);          // pin7 interrupt input
        setpin(7, 1'b1); edges(3);
        rd_chk("R11 status without enable", A_STAT, 16'h0080);
        chk("R11 irq masked", 32'(irq), 0);
        wr(A_IEN, 16'h0080);
        @(negedge clk);
        chk("R11 irq enabled", 32'(irq), 1);
        wr(A_IEN, 16'h007F);
        @(negedge clk);
        chk("R11 other enables", 32'(irq), 0);
        wr(A_IEN, 16'h0080);
        setpin(7, 1'b0); edges(3);
        wr(A_STAT, 16'h0080);
        @(negedge clk);
        chk("R11 irq drops", 32'(irq), 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_regmap();
        t_output();
        t_periph();
        t_sync();
        t_rise();
        t_fall();
        t_level();
        t_sticky();
        t_plain();
        t_irq();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(20000 * 4);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule